// File: doc/BRIEF.md
# Internal Data Space Operand Resolver

This block turns the operand of an 8-bit microcontroller instruction into an access to its 256-byte internal data space. The space is split by the top address bit: the lower half is general-purpose RAM and the upper half holds the special function registers (SFRs). Four operand kinds are handled: a plain direct byte address, a working register of the active bank, a pointer held in one of the first two registers of the active bank, and a single bit of the separate bit-address space.

A request is accepted in one cycle. The block then drives a synchronous byte bus with a one-cycle read latency. For single-bit operations it reads the byte that holds the bit, changes only that bit, and writes the byte back. It returns the byte as it was read and, for bit operands, the old value of the bit. The bank is taken from bits 4 and 3 of the status word that is presented with the request.

The controller is a seven-state machine:

- **IDLE** is the rest state. A request moves it to **PTR_RD** when the operand is indirect, and to **ACC_RD** for every other operand.
- **PTR_RD** issues the read of the pointer register and always moves to **PTR_CAP**.
- **PTR_CAP** latches the pointer as the target address and moves to **ACC_RD**.
- **ACC_RD** issues the read of the target byte and moves to **ACC_CAP**.
- **ACC_CAP** latches the byte and the old bit. It moves to **WRITE** when a write-back is needed and to **DONE** when none is needed.
- **WRITE** drives the modified byte and moves to **DONE**.
- **DONE** raises the completion strobe for one cycle and returns to **IDLE**.

Top module: `idata_addr_resolver`

## Requirements
- R1: After reset the block is idle. busy, done, mem_rd and mem_wr are 0, and result_byte and result_bit are 0.
- R2: Direct mode (req_mode 00) reads the byte at address req_operand. mem_sfr_sel equals bit 7 of the operand. result_byte returns that byte. req_op has no effect in this mode.
- R3: Register mode (req_mode 01) reads RAM at the address bank*8 + req_operand[2:0]. The bank is psw[4:3]. mem_sfr_sel is 0.
- R4: Indirect mode (req_mode 10) first reads the pointer register at RAM address bank*8 + req_operand[0]. It then reads RAM at the address held in that register. The second read has mem_sfr_sel = 0 even when the pointer is 80h or above.
- R5: In bit mode (req_mode 11), a bit address below 80h selects RAM byte 20h + (bit address >> 3). bit_index is the low three bits of the bit address.
- R6: In bit mode, a bit address of 80h or above selects the SFR whose address is the bit address with its low three bits cleared. mem_sfr_sel is 1 and bit_index is the low three bits.
- R7: The bit operations set (req_op 001), clear (010) and complement (011) read the byte, then write it back one cycle after the read data arrives. Only the selected bit changes.
- R8: Test-and-clear (req_op 100) returns the old bit in result_bit. It writes the byte back with that bit cleared only when the old bit was 1. When the old bit was 0, no write occurs.
- R9: Bit test (req_op 000, and the unused codes 101 to 111) returns the selected bit in result_bit and the whole byte in result_byte. It performs no write.
- R10: done is a one-cycle pulse. It is seen 3 cycles after the accepting edge for a read. A write-back adds 1 cycle and indirect mode adds 2 cycles.
- R11: While busy, req_valid, req_mode, req_op, req_operand and psw are ignored. Bank and operand are taken only at the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken only when idle |
| req_mode | input | 2 | Operand kind: 00 direct, 01 register, 10 indirect, 11 bit |
| req_op | input | 3 | Bit operation: 000 test, 001 set, 010 clear, 011 complement, 100 test-and-clear |
| req_operand | input | 8 | Byte address, register number, pointer select or bit address |
| psw | input | 8 | Status word; bits 4:3 pick the register bank |
| busy | output | 1 | High from the accepting edge until the return to idle |
| done | output | 1 | One-cycle completion pulse |
| result_byte | output | 8 | Byte read from the target address |
| result_bit | output | 1 | Old value of the selected bit (bit mode) |
| bit_index | output | 3 | Bit position inside the target byte |
| mem_addr | output | 8 | Byte address on the internal bus |
| mem_sfr_sel | output | 1 | 1 selects the SFR space, 0 selects RAM |
| mem_rd | output | 1 | Read strobe; data returns on mem_rdata one cycle later |
| mem_wr | output | 1 | Write strobe |
| mem_wdata | output | 8 | Byte written back |
| mem_rdata | input | 8 | Read data, valid the cycle after mem_rd |

## Verification
Directed cases cover both ends of each mapping:

- direct addresses on each side of 80h;
- R0 and R7 in banks 0 and 3;
- bit addresses 00h and 7Fh, which tell the 20h offset apart from the SFR alignment;
- SFR bits in the status word and the accumulator;
- a test-and-clear on a set bit and then on the same, now cleared, bit. This separates a conditional write from an unconditional one.

Random requests of every mode and operation run from a fixed seed. Each carries a random status word. While an operation is in progress the bench drives random requests and status words. This shows whether the bank or operand is sampled late, and whether a request is taken while busy. Latency, bus address, space select, written data and returned values are compared against a shadow copy of the data space kept in the bench. Random pointer contents exercise indirect targets above 7Fh.

// File: rtl/idata_pkg.sv
package idata_pkg;

    typedef enum logic [1:0] {
        MODE_DIRECT   = 2'b00,
        MODE_REG      = 2'b01,
        MODE_INDIRECT = 2'b10,
        MODE_BIT      = 2'b11
    } opnd_mode_e;

    typedef enum logic [2:0] {
        BOP_TEST     = 3'b000,
        BOP_SET      = 3'b001,
        BOP_CLEAR    = 3'b010,
        BOP_TOGGLE   = 3'b011,
        BOP_TEST_CLR = 3'b100
    } bit_op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_PTR_RD,
        S_PTR_CAP,
        S_ACC_RD,
        S_ACC_CAP,
        S_WRITE,
        S_DONE
    } fsm_state_e;

endpackage

// File: rtl/idata_bank_map.sv
// Working-register number plus bank select -> RAM byte address.
module idata_bank_map #(
    parameter int ADDR_W        = 8,
    parameter int NUM_BANKS     = 4,
    parameter int REGS_PER_BANK = 8,
    localparam int BANK_W       = $clog2(NUM_BANKS),
    localparam int REG_W        = $clog2(REGS_PER_BANK)
) (
    input  logic [BANK_W-1:0] bank_i,
    input  logic [REG_W-1:0]  reg_i,
    output logic [ADDR_W-1:0] addr_o
);

    // Banks are packed back to back from address zero.
    assign addr_o = ADDR_W'({bank_i, reg_i});

endmodule

// File: rtl/idata_bit_map.sv
// Bit address -> containing byte, space select and bit position.
module idata_bit_map #(
    parameter int              ADDR_W        = 8,
    parameter int              DATA_W        = 8,
    parameter logic [ADDR_W-1:0] BIT_AREA_BASE = 8'h20,
    localparam int             IDX_W         = $clog2(DATA_W)
) (
    input  logic [ADDR_W-1:0] bit_addr_i,
    output logic [ADDR_W-1:0] byte_addr_o,
    output logic              is_sfr_o,
    output logic [IDX_W-1:0]  idx_o
);

    logic [ADDR_W-IDX_W-1:0] byte_sel;

    assign byte_sel = bit_addr_i[ADDR_W-1:IDX_W];
    assign idx_o    = bit_addr_i[IDX_W-1:0];
    assign is_sfr_o = bit_addr_i[ADDR_W-1];

    always_comb begin
        if (is_sfr_o) begin
            // Upper half: the byte address is the bit address with the
            // position bits cleared.
            byte_addr_o = {byte_sel, IDX_W'(0)};
        end else begin
            // Lower half: folds onto a window of RAM bytes.
            byte_addr_o = BIT_AREA_BASE + ADDR_W'(byte_sel);
        end
    end

endmodule

// File: rtl/idata_bit_modify.sv
// Computes the written-back byte for a single-bit operation.
module idata_bit_modify
    import idata_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int IDX_W = $clog2(DATA_W)
) (
    input  logic [2:0]        op_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic [IDX_W-1:0]  idx_i,
    output logic [DATA_W-1:0] byte_o,
    output logic              old_bit_o,
    output logic              write_o
);

    assign old_bit_o = byte_i[idx_i];

    for (genvar g = 0; g < DATA_W; g++) begin : g_bit
        logic hit;
        assign hit = (idx_i == IDX_W'(g));
        always_comb begin
            byte_o[g] = byte_i[g];
            if (hit) begin
                case (op_i)
                    BOP_SET:      byte_o[g] = 1'b1;
                    BOP_CLEAR:    byte_o[g] = 1'b0;
                    BOP_TOGGLE:   byte_o[g] = ~byte_i[g];
                    BOP_TEST_CLR: byte_o[g] = 1'b0;
                    default:      byte_o[g] = byte_i[g];
                endcase
            end
        end
    end

    always_comb begin
        case (op_i)
            BOP_SET, BOP_CLEAR, BOP_TOGGLE: write_o = 1'b1;
            BOP_TEST_CLR:                   write_o = old_bit_o;
            default:                        write_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/idata_addr_resolver.sv
module idata_addr_resolver
    import idata_pkg::*;
#(
    parameter int                ADDR_W        = 8,
    parameter int                DATA_W        = 8,
    parameter int                NUM_BANKS     = 4,
    parameter int                REGS_PER_BANK = 8,
    parameter int                BANK_LSB      = 3,
    parameter logic [ADDR_W-1:0] BIT_AREA_BASE = 8'h20,
    localparam int               BANK_W        = $clog2(NUM_BANKS),
    localparam int               REG_W         = $clog2(REGS_PER_BANK),
    localparam int               IDX_W         = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_mode,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_operand,
    input  logic [DATA_W-1:0] psw,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] result_byte,
    output logic              result_bit,
    output logic [IDX_W-1:0]  bit_index,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_sfr_sel,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);

    fsm_state_e  state, state_nx;
    opnd_mode_e  mode_q, mode_in;
    logic [2:0]  op_q;
    logic [ADDR_W-1:0] tgt_addr_q, tgt_addr_c;
    logic        tgt_sfr_q, tgt_sfr_c;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] byte_q, wdata_q;
    logic        bitv_q;

    logic [BANK_W-1:0] bank_c;
    logic [REG_W-1:0]  reg_c;
    logic [ADDR_W-1:0] reg_addr_c;
    logic [ADDR_W-1:0] bit_byte_c;
    logic        bit_sfr_c;
    logic [IDX_W-1:0]  bit_idx_c;
    logic [DATA_W-1:0] mod_byte;
    logic        mod_old_bit, mod_write;
    logic        accept, wb_needed;

    assign mode_in = opnd_mode_e'(req_mode);
    assign accept  = (state == S_IDLE) && req_valid;
    assign bank_c  = psw[BANK_LSB +: BANK_W];
    // Indirect operands can only name the first two registers of a bank.
    assign reg_c   = (mode_in == MODE_INDIRECT) ? REG_W'(req_operand[0])
                                                 : req_operand[REG_W-1:0];

    idata_bank_map #(
        .ADDR_W        (ADDR_W),
        .NUM_BANKS     (NUM_BANKS),
        .REGS_PER_BANK (REGS_PER_BANK)
    ) u_bank (
        .bank_i (bank_c),
        .reg_i  (reg_c),
        .addr_o (reg_addr_c)
    );

    idata_bit_map #(
        .ADDR_W        (ADDR_W),
        .DATA_W        (DATA_W),
        .BIT_AREA_BASE (BIT_AREA_BASE)
    ) u_bitmap (
        .bit_addr_i  (req_operand),
        .byte_addr_o (bit_byte_c),
        .is_sfr_o    (bit_sfr_c),
        .idx_o       (bit_idx_c)
    );

    idata_bit_modify #(
        .DATA_W (DATA_W)
    ) u_modify (
        .op_i      (op_q),
        .byte_i    (mem_rdata),
        .idx_i     (idx_q),
        .byte_o    (mod_byte),
        .old_bit_o (mod_old_bit),
        .write_o   (mod_write)
    );

    assign wb_needed = (mode_q == MODE_BIT) && mod_write;

    // First target of the request (for indirect: the pointer register).
    always_comb begin
        unique case (mode_in)
            MODE_DIRECT: begin
                tgt_addr_c = req_operand;
                tgt_sfr_c  = req_operand[ADDR_W-1];
            end
            MODE_REG, MODE_INDIRECT: begin
                tgt_addr_c = reg_addr_c;
                tgt_sfr_c  = 1'b0;
            end
            MODE_BIT: begin
                tgt_addr_c = bit_byte_c;
                tgt_sfr_c  = bit_sfr_c;
            end
            default: begin
                tgt_addr_c = '0;
                tgt_sfr_c  = 1'b0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // Transitions.
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:    if (req_valid) state_nx = (mode_in == MODE_INDIRECT) ? S_PTR_RD : S_ACC_RD;
            S_PTR_RD:  state_nx = S_PTR_CAP;
            S_PTR_CAP: state_nx = S_ACC_RD;
            S_ACC_RD:  state_nx = S_ACC_CAP;
            S_ACC_CAP: state_nx = wb_needed ? S_WRITE : S_DONE;
            S_WRITE:   state_nx = S_DONE;
            S_DONE:    state_nx = S_IDLE;
            default:   state_nx = S_IDLE;
        endcase
    end

    // Datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MODE_DIRECT;
            op_q       <= '0;
            tgt_addr_q <= '0;
            tgt_sfr_q  <= 1'b0;
            idx_q      <= '0;
            byte_q     <= '0;
            wdata_q    <= '0;
            bitv_q     <= 1'b0;
        end else begin
            if (accept) begin
                mode_q     <= mode_in;
                op_q       <= req_op;
                tgt_addr_q <= tgt_addr_c;
                tgt_sfr_q  <= tgt_sfr_c;
                idx_q      <= (mode_in == MODE_BIT) ? bit_idx_c : '0;
            end
            if (state == S_PTR_CAP) begin
                // Indirect targets always live in RAM.
                tgt_addr_q <= ADDR_W'(mem_rdata);
                tgt_sfr_q  <= 1'b0;
            end
            if (state == S_ACC_CAP) begin
                byte_q  <= mem_rdata;
                wdata_q <= mod_byte;
                bitv_q  <= (mode_q == MODE_BIT) ? mod_old_bit : 1'b0;
            end
        end
    end

    // Outputs.
    always_comb begin
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        mem_addr    = '0;
        mem_sfr_sel = 1'b0;
        mem_wdata   = '0;
        done        = 1'b0;
        unique case (state)
            S_PTR_RD: begin
                mem_rd   = 1'b1;
                mem_addr = tgt_addr_q;
            end
            S_ACC_RD: begin
                mem_rd      = 1'b1;
                mem_addr    = tgt_addr_q;
                mem_sfr_sel = tgt_sfr_q;
            end
            S_WRITE: begin
                mem_wr      = 1'b1;
                mem_addr    = tgt_addr_q;
                mem_sfr_sel = tgt_sfr_q;
                mem_wdata   = wdata_q;
            end
            S_DONE:  done = 1'b1;
            default: ;
        endcase
    end

    assign busy        = (state != S_IDLE);
    assign result_byte = byte_q;
    assign result_bit  = bitv_q;
    assign bit_index   = idx_q;

endmodule

// File: rtl/idata_addr_resolver_chk.sv
module idata_addr_resolver_chk #(
    parameter int                ADDR_W        = 8,
    parameter int                DATA_W        = 8,
    parameter logic [ADDR_W-1:0] BIT_AREA_BASE = 8'h20
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              done,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_sfr_sel,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] mem_rdata
);

    localparam int IDX_W   = $clog2(DATA_W);
    localparam int WIN_LO  = int'(BIT_AREA_BASE);
    localparam int WIN_HI  = WIN_LO + (2 ** (ADDR_W - 1)) / DATA_W;

    // R1
    idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr && !done));

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10
    done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (busy && !mem_rd && !mem_wr));

    // R7
    wr_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($past(mem_rd, 2) && mem_addr == $past(mem_addr, 2)
                    && mem_sfr_sel == $past(mem_sfr_sel, 2)));

    // R7
    wr_single_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> ($countones(mem_wdata ^ $past(mem_rdata)) <= 1));

    // R8
    tclr_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> !(mem_rd));

    // R5
    ram_bit_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && !mem_sfr_sel) |-> (int'(mem_addr) >= WIN_LO && int'(mem_addr) < WIN_HI));

    // R6
    sfr_bit_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr && mem_sfr_sel) |-> (mem_addr[IDX_W-1:0] == '0 && mem_addr[ADDR_W-1]));

endmodule

bind idata_addr_resolver idata_addr_resolver_chk #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .BIT_AREA_BASE (BIT_AREA_BASE)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .busy        (busy),
    .done        (done),
    .mem_addr    (mem_addr),
    .mem_sfr_sel (mem_sfr_sel),
    .mem_rd      (mem_rd),
    .mem_wr      (mem_wr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata)
);

// File: tb/sim_idata_addr_resolver.sv
`timescale 1ns/1ps
module sim_idata_addr_resolver;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_mode = '0;
    logic [2:0] req_op = '0;
    logic [7:0] req_operand = '0;
    logic [7:0] psw = '0;
    logic       busy, done, result_bit, mem_sfr_sel, mem_rd, mem_wr;
    logic [7:0] result_byte, mem_addr, mem_wdata;
    logic [7:0] mem_rdata;
    logic [2:0] bit_index;

    int checks = 0;
    int fails  = 0;
    bit summary_done = 1'b0;

    always #2.5 clk = ~clk;

    idata_addr_resolver u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_op(req_op), .req_operand(req_operand), .psw(psw), .busy(busy),
        .done(done), .result_byte(result_byte), .result_bit(result_bit),
        .bit_index(bit_index), .mem_addr(mem_addr), .mem_sfr_sel(mem_sfr_sel),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    function automatic logic [7:0] init_ram(int a);
        return 8'((a * 29 + 7) ^ (a >> 2));
    endfunction

    function automatic logic [7:0] init_sfr(int a);
        return 8'(a * 53 + 17);
    endfunction

    // Memory model and bus monitor.
    logic [7:0] ram_mem [256];
    logic [7:0] sfr_mem [256];
    int   rd_count = 0, wr_count = 0;
    logic [7:0] last_rd_addr = '0, last_wr_addr = '0, last_wr_data = '0;
    logic       last_rd_sfr = 1'b0, last_wr_sfr = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) begin
                ram_mem[i] <= init_ram(i);
                sfr_mem[i] <= init_sfr(i);
            end
            mem_rdata <= '0;
        end else begin
            if (mem_rd) begin
                mem_rdata    <= mem_sfr_sel ? sfr_mem[mem_addr] : ram_mem[mem_addr];
                rd_count     <= rd_count + 1;
                last_rd_addr <= mem_addr;
                last_rd_sfr  <= mem_sfr_sel;
            end
            if (mem_wr) begin
                if (mem_sfr_sel) sfr_mem[mem_addr] <= mem_wdata;
                else             ram_mem[mem_addr] <= mem_wdata;
                wr_count     <= wr_count + 1;
                last_wr_addr <= mem_addr;
                last_wr_sfr  <= mem_sfr_sel;
                last_wr_data <= mem_wdata;
            end
        end
    end

    // Shadow of the data space, kept from the requirements only.
    logic [7:0] sh_ram [256];
    logic [7:0] sh_sfr [256];

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] mode, input logic [2:0] op,
                         input logic [7:0] opnd, input logic [7:0] pv,
                         input bit junk);
        logic [1:0] bank;
        logic [7:0] ea, pa, ebyte, enew;
        logic       esfr, eold;
        logic [2:0] eidx;
        bit         ewr;
        int         lat, n, rd0, wr0;
        string      tag;
        bank = pv[4:3];
        esfr = 1'b0; eidx = '0; ewr = 1'b0; eold = 1'b0; lat = 3;
        case (mode)
            2'b00: begin ea = opnd; esfr = opnd[7]; tag = "R2"; end
            2'b01: begin ea = {3'b0, bank, opnd[2:0]}; tag = "R3"; end
            2'b10: begin pa = {3'b0, bank, 2'b0, opnd[0]}; ea = sh_ram[pa]; lat = 5; tag = "R4"; end
            default: begin
                if (opnd[7]) begin ea = {opnd[7:3], 3'b0}; esfr = 1'b1; tag = "R6"; end
                else begin ea = 8'h20 + (opnd >> 3); tag = "R5"; end
                eidx = opnd[2:0];
            end
        endcase
        ebyte = esfr ? sh_sfr[ea] : sh_ram[ea];
        enew  = ebyte;
        if (mode == 2'b11) begin
            eold = ebyte[eidx];
            case (op)
                3'b001: begin enew[eidx] = 1'b1; ewr = 1'b1; end
                3'b010: begin enew[eidx] = 1'b0; ewr = 1'b1; end
                3'b011: begin enew[eidx] = ~ebyte[eidx]; ewr = 1'b1; end
                3'b100: begin enew[eidx] = 1'b0; ewr = eold; end
                default: ;
            endcase
            if (ewr) lat = 4;
        end

        @(negedge clk);
        rd0 = rd_count; wr0 = wr_count;
        req_valid = 1'b1; req_mode = mode; req_op = op; req_operand = opnd; psw = pv;
        n = 0;
        forever begin
            @(negedge clk);
            n++;
            if (done || n > 20) break;
            if (junk) begin
                req_valid = 1'($urandom); req_mode = 2'($urandom); req_op = 3'($urandom);
                req_operand = 8'($urandom); psw = 8'($urandom);
            end else begin
                req_valid = 1'b0;
            end
        end
        req_valid = 1'b0;

        // R10, R11: latency and a single completion per request
        chk(done && n == lat, "R10 latency", n, lat);
        chk(result_byte == ebyte, {tag, "/R11 result_byte"}, result_byte, ebyte);
        chk(last_rd_addr == ea && last_rd_sfr == esfr, {tag, " read address"},
            {last_rd_sfr, last_rd_addr}, {esfr, ea});
        chk(rd_count - rd0 == ((mode == 2'b10) ? 2 : 1), {tag, " read count"},
            rd_count - rd0, (mode == 2'b10) ? 2 : 1);
        if (mode == 2'b11) begin
            chk(bit_index == eidx, {tag, " bit_index"}, bit_index, eidx);
            chk(result_bit == eold, (op == 3'b100) ? "R8 old bit" : "R9 bit value",
                result_bit, eold);
        end
        // R7 R8 R9: write-back only where required, with one bit changed
        chk(wr_count - wr0 == int'(ewr), "R7/R8/R9 write count", wr_count - wr0, ewr);
        if (ewr) begin
            chk(last_wr_addr == ea && last_wr_sfr == esfr && last_wr_data == enew,
                "R7/R8 write-back", {last_wr_sfr, last_wr_addr, last_wr_data},
                {esfr, ea, enew});
            if (esfr) sh_sfr[ea] = enew;
            else      sh_ram[ea] = enew;
        end
        chk((esfr ? sfr_mem[ea] : ram_mem[ea]) == enew, "R7 stored byte",
            esfr ? sfr_mem[ea] : ram_mem[ea], enew);
        @(negedge clk);
        chk(!busy && !done, "R10 back to idle", {busy, done}, 0);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            sh_ram[i] = init_ram(i);
            sh_sfr[i] = init_sfr(i);
        end
        void'($urandom(32'h5eed_0101));
        repeat (3) @(negedge clk);
        // R1: state after reset
        chk(!busy && !done && !mem_rd && !mem_wr, "R1 control outputs",
            {busy, done, mem_rd, mem_wr}, 0);
        chk(result_byte == 8'h00 && !result_bit, "R1 results", {result_bit, result_byte}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        do_op(2'b00, 3'b011, 8'h45, 8'h00, 1'b0);  // R2 RAM, op ignored
        do_op(2'b00, 3'b001, 8'h90, 8'h00, 1'b0);  // R2 SFR
        do_op(2'b01, 3'b000, 8'h07, 8'h18, 1'b0);  // R3 R7 bank 3 -> 1Fh
        do_op(2'b01, 3'b000, 8'h00, 8'h00, 1'b0);  // R3 R0 bank 0
        do_op(2'b10, 3'b000, 8'h01, 8'h10, 1'b0);  // R4 @R1 bank 2
        do_op(2'b10, 3'b000, 8'h00, 8'h08, 1'b1);  // R4/R11 @R0 bank 1
        do_op(2'b11, 3'b001, 8'h00, 8'h00, 1'b0);  // R5/R7 20h.0 set
        do_op(2'b11, 3'b010, 8'h7F, 8'h00, 1'b0);  // R5/R7 2Fh.7 clear
        do_op(2'b11, 3'b011, 8'hD7, 8'h00, 1'b0);  // R6/R7 D0h.7 complement
        do_op(2'b11, 3'b000, 8'hE3, 8'h00, 1'b0);  // R6/R9 test
        do_op(2'b11, 3'b001, 8'h35, 8'h00, 1'b0);  // R8 prepare: set 26h.5
        do_op(2'b11, 3'b100, 8'h35, 8'h00, 1'b0);  // R8 set bit -> written clear
        do_op(2'b11, 3'b100, 8'h35, 8'h00, 1'b0);  // R8 clear bit -> no write
        do_op(2'b11, 3'b111, 8'h88, 8'h00, 1'b0);  // R9 unused code is a test

        // Random mix
        for (int k = 0; k < 400; k++) begin
            do_op(2'($urandom), 3'($urandom), 8'($urandom), 8'($urandom), 1'($urandom));
        end

        if (!summary_done) begin
            summary_done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
        $finish;
    end

    initial begin
        #(150000 * 5);
        if (!summary_done) begin
            summary_done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        end
        $finish;
    end

endmodule